// File: doc/BRIEF.md
# Warp Interleaving Issue Scheduler

This block chooses, on every clock cycle, which warp of a fine-grained multithreaded SIMD pipeline sends its next instruction down the pipe. Each warp stands for a group of threads that share one instruction stream. The block keeps a small state machine for every warp. A warp that already has an instruction in the pipe cannot be chosen again. The warp becomes eligible only after writeback reports that instruction complete. There is no speculative issue past an unresolved instruction.

If a warp's data access misses in the data cache, the cache stage reports the miss. The warp is then parked until a memory-return notice names it. Other ready warps keep the pipe busy in the meantime, so pipeline and memory latency are hidden. Among ready warps the choice is round-robin. The search starts at the warp after the one issued most recently. The result is a registered issue strobe and the chosen warp number.

Each warp slot has four states: `WS_IDLE` (not taking part), `WS_READY` (eligible), `WS_BUSY` (one instruction in flight) and `WS_PARKED` (waiting on memory). The transitions are:
- **activate**: IDLE to READY when the warp's active bit is set.
- **drop**: READY to IDLE when the active bit clears and the warp is not granted.
- **grant**: READY to BUSY when the warp is picked.
- **complete**: BUSY to READY, or to IDLE if the warp is inactive.
- **miss**: BUSY to PARKED.
- **return**: PARKED to READY, or to IDLE if the warp is inactive.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset every warp is IDLE and `issue_valid` is 0. While no warp is active, `issue_valid` stays 0.
- R2: A warp that is IDLE and has its `warp_active` bit set becomes READY at the next edge. A READY warp whose active bit is clear, and which is not granted in that cycle, returns to IDLE and is not issued.
- R3: If at least one warp is READY at a clock edge, `issue_valid` is 1 after that edge and `issue_wid` names a warp that was READY. If no warp is READY at the edge, `issue_valid` is 0 after it.
- R4: The grant goes to the first READY warp found by searching upward from the last issued warp plus one, wrapping from NUM_WARPS-1 to 0. After reset the search starts at warp 0. At most one warp is granted per cycle.
- R5: A warp has at most one instruction in flight. Once issued, it is not issued again until a completion or memory return has made it READY.
- R6: A completion notice (`done_valid` with `done_wid`) that names a BUSY warp makes it READY at the next edge. If the warp's active bit is clear, it becomes IDLE instead.
- R7: A miss notice (`miss_valid` with `miss_wid`) that names a BUSY warp parks it. A parked warp is not issued until it receives a memory return. If a miss and a completion name the same warp in the same cycle, the miss wins.
- R8: A memory return (`ret_valid` with `ret_wid`) that names a PARKED warp makes it READY at the next edge, or IDLE if the warp is inactive.
- R9: A completion, miss or return notice that names a warp not in the matching state (BUSY for completion and miss, PARKED for return) has no effect.
- R10: A warp that has become READY is issued within NUM_WARPS clock edges while it stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_active | input | NUM_WARPS | Per-warp participation enable |
| done_valid | input | 1 | Completion notice from writeback |
| done_wid | input | WID_W | Warp named by the completion notice |
| miss_valid | input | 1 | Data cache miss notice |
| miss_wid | input | WID_W | Warp named by the miss notice |
| ret_valid | input | 1 | Memory data return notice |
| ret_wid | input | WID_W | Warp named by the memory return |
| issue_valid | output | 1 | Registered issue strobe |
| issue_wid | output | WID_W | Warp issued; meaningful when `issue_valid` is 1 |

## Verification
On every cycle the assertions check the following: a grant only ever reaches a READY slot; grants are one-hot or empty; the strobe follows whether any slot was READY; an issued warp is BUSY; the same warp is never issued on two consecutive cycles. They also check, cycle by cycle, the slot transitions for drop, miss, park-hold and return. Only the bench scenarios can show the full round-robin order and the wrap-around. The same applies to miss-over-completion priority, ignored stray notices and the fairness bound over a long run of completions.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_READY  = 2'd1,
        WS_BUSY   = 2'd2,
        WS_PARKED = 2'd3
    } warp_st_e;
endpackage

// File: rtl/warp_slot.sv
module warp_slot
    import warp_sched_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     grant,
    input  logic     done_hit,
    input  logic     miss_hit,
    input  logic     ret_hit,
    output warp_st_e state
);
    warp_st_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            WS_IDLE:   if (active) nxt = WS_READY;
            WS_READY:  if (grant) nxt = WS_BUSY;
                       else if (!active) nxt = WS_IDLE;
            WS_BUSY:   if (miss_hit) nxt = WS_PARKED;
                       else if (done_hit) nxt = active ? WS_READY : WS_IDLE;
            WS_PARKED: if (ret_hit) nxt = active ? WS_READY : WS_IDLE;
            default:   nxt = WS_IDLE;
        endcase
    end

    p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> state == WS_READY);
    p_drop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_READY && !active && !grant) |=> state == WS_IDLE);
    p_miss_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_BUSY && miss_hit) |=> state == WS_PARKED);
    p_park_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_PARKED && !ret_hit) |=> state == WS_PARKED);
    p_ret_wakes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_PARKED && ret_hit && active) |=> state == WS_READY);
    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WS_IDLE && !active) |=> state == WS_IDLE);
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 32,
    parameter int W = 5
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         any,
    output logic [W-1:0] pick,
    output logic [N-1:0] gnt
);
    // search upward from last+1, wrapping
    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!any && req[idx]) begin
                any  = 1'b1;
                pick = W'(idx);
            end
        end
        gnt = any ? (N'(1) << pick) : '0;
    end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 32,
    localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] warp_active,
    input  logic                 done_valid,
    input  logic [WID_W-1:0]     done_wid,
    input  logic                 miss_valid,
    input  logic [WID_W-1:0]     miss_wid,
    input  logic                 ret_valid,
    input  logic [WID_W-1:0]     ret_wid,
    output logic                 issue_valid,
    output logic [WID_W-1:0]     issue_wid
);
    warp_st_e             slot_st [NUM_WARPS];
    logic [NUM_WARPS-1:0] ready_vec;
    logic [NUM_WARPS-1:0] grant_vec;
    logic                 any_ready;
    logic [WID_W-1:0]     pick_wid;
    logic [WID_W-1:0]     last_wid;

    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_slot
        warp_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (warp_active[g]),
            .grant    (grant_vec[g]),
            .done_hit (done_valid && done_wid == WID_W'(g)),
            .miss_hit (miss_valid && miss_wid == WID_W'(g)),
            .ret_hit  (ret_valid && ret_wid == WID_W'(g)),
            .state    (slot_st[g])
        );
        assign ready_vec[g] = (slot_st[g] == WS_READY);
    end

    rr_pick #(.N(NUM_WARPS), .W(WID_W)) u_pick (
        .req  (ready_vec),
        .last (last_wid),
        .any  (any_ready),
        .pick (pick_wid),
        .gnt  (grant_vec)
    );

    // registered issue outputs and round-robin pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_wid   <= '0;
            last_wid    <= WID_W'(NUM_WARPS - 1);
        end else begin
            issue_valid <= any_ready;
            if (any_ready) begin
                issue_wid <= pick_wid;
                last_wid  <= pick_wid;
            end
        end
    end

    p_none_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_vec == '0) |=> !issue_valid);
    p_some_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_vec != '0) |=> issue_valid);
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));
    p_issued_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> slot_st[issue_wid] == WS_BUSY);
    p_no_reissue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> !(issue_valid && issue_wid == $past(issue_wid)));
endmodule

// File: tb/tb_warp_issue_sched.sv
module tb_warp_issue_sched;
    localparam int N = 8;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] act;
    logic         done_v, miss_v, ret_v;
    logic [W-1:0] done_w, miss_w, ret_w;
    logic         iv;
    logic [W-1:0] iw;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(N)) dut (
        .clk(clk), .rst_n(rst_n), .warp_active(act),
        .done_valid(done_v), .done_wid(done_w),
        .miss_valid(miss_v), .miss_wid(miss_w),
        .ret_valid(ret_v), .ret_wid(ret_w),
        .issue_valid(iv), .issue_wid(iw)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_in();
        done_v = 0; miss_v = 0; ret_v = 0;
        done_w = '0; miss_w = '0; ret_w = '0;
    endtask

    task automatic do_reset();
        clear_in();
        act = '0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic check_out(string req, bit ev, int ew);
        checks++;
        if (iv !== ev || (ev && iw !== W'(ew))) begin
            failures++;
            $display("FAIL %s: issue_valid=%0b wid=%0d expected valid=%0b wid=%0d",
                     req, iv, iw, ev, ew);
        end
    endtask

    task automatic check_true(string req, bit ok, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic t_reset();
        do_reset();
        check_out("R1 reset", 0, 0);
        tick(); tick();
        check_out("R1 no active warp", 0, 0);
    endtask

    task automatic t_order();
        do_reset();
        act = 8'b0010_0101;
        tick(); check_out("R3 ready not yet issued", 0, 0);
        tick(); check_out("R4 first 0", 1, 0);
        tick(); check_out("R4 then 2", 1, 2);
        tick(); check_out("R4 then 5", 1, 5);
        tick(); check_out("R5 all busy", 0, 0);
        done_v = 1; done_w = 3'd2;
        tick(); clear_in();
        tick(); check_out("R6 completion reissues", 1, 2);
    endtask

    task automatic t_wrap();
        do_reset();
        act = 8'hFF;
        tick();
        for (int k = 0; k < N; k++) begin
            tick(); check_out("R4 ascending", 1, k);
        end
        tick(); check_out("R5 all in flight", 0, 0);
        done_v = 1; done_w = 3'd3;
        tick(); clear_in();
        miss_v = 1; miss_w = 3'd1;
        tick(); clear_in(); check_out("R6 warp 3", 1, 3);
        done_v = 1; done_w = 3'd6; ret_v = 1; ret_w = 3'd1;
        tick(); clear_in(); check_out("R3 none ready", 0, 0);
        tick(); check_out("R4 after last picks 6", 1, 6);
        tick(); check_out("R4 wrap picks 1", 1, 1);
        tick(); check_out("R5 quiet", 0, 0);
    endtask

    task automatic t_miss();
        do_reset();
        act = 8'b0001_0000;
        tick(); tick(); check_out("R3 single warp", 1, 4);
        miss_v = 1; miss_w = 3'd4; done_v = 1; done_w = 3'd4;
        tick(); clear_in(); check_out("R7 miss", 0, 0);
        done_v = 1; done_w = 3'd4;
        tick(); clear_in();
        tick(); check_out("R9 stray completion on parked", 0, 0);
        tick(); check_out("R7 still parked", 0, 0);
        ret_v = 1; ret_w = 3'd4;
        tick(); clear_in();
        tick(); check_out("R8 return reissues", 1, 4);
        ret_v = 1; ret_w = 3'd4;
        tick(); clear_in();
        tick(); check_out("R9 stray return on busy", 0, 0);
    endtask

    task automatic t_inactive();
        do_reset();
        act = 8'b0000_0110;
        tick();
        act = 8'b0000_0010;
        tick(); check_out("R2 issue 1", 1, 1);
        tick(); check_out("R2 dropped warp not issued", 0, 0);
        act = '0;
        done_v = 1; done_w = 3'd1;
        tick(); clear_in();
        tick(); check_out("R6 inactive completes to idle", 0, 0);
        act = 8'b0000_0100;
        tick();
        tick(); check_out("R2 reactivated", 1, 2);
    endtask

    task automatic t_fair();
        logic [N-1:0] outst;
        int waitc [N];
        int rot, r5bad, fairbad, issued, maxw;
        bit dv;
        logic [W-1:0] dw;
        do_reset();
        outst = '0; rot = 0; r5bad = 0; fairbad = 0; issued = 0; maxw = 0;
        for (int k = 0; k < N; k++) waitc[k] = 0;
        act = '1;
        for (int cyc = 0; cyc < 400; cyc++) begin
            clear_in();
            if (cyc % 4 != 3) begin
                for (int k = 0; k < N; k++) begin
                    int w;
                    w = (rot + k) % N;
                    if (!done_v && outst[w]) begin
                        done_v = 1; done_w = W'(w);
                    end
                end
            end
            rot = (rot + 3) % N;
            dv = done_v; dw = done_w;
            tick();
            if (dv) begin outst[dw] = 0; waitc[dw] = 0; end
            if (iv) begin
                if (outst[iw]) r5bad++;
                outst[iw] = 1; waitc[iw] = 0; issued++;
            end
            for (int k = 0; k < N; k++) begin
                if (!outst[k] && !(iv && iw == W'(k))) begin
                    waitc[k]++;
                    if (waitc[k] > maxw) maxw = waitc[k];
                    if (waitc[k] > N + 1) fairbad++;
                end
            end
        end
        clear_in();
        check_true("R5 no double issue", r5bad == 0, r5bad, 0);
        check_true("R10 bounded wait", fairbad == 0, maxw, N + 1);
        check_true("R6 steady issue", issued > 250, issued, 251);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 0;
        clear_in();
        act = '0;
        t_reset();
        t_order();
        t_wrap();
        t_miss();
        t_inactive();
        t_fair();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule